// File: doc/BRIEF.md
# SPI Register Transaction Master

This block runs single register accesses on an external SPI peripheral. A request names a 6-bit register, a 15-bit sub-address, a direction and a byte count of up to eight. The block then asserts chip-select and sends a header of one, two or three bytes. The header length follows from the sub-address value. After the header comes the data phase: for a write it carries the supplied bytes, and for a read it carries zero bytes while the incoming bytes are collected. When chip-select is released, the block pulses `done` and holds the assembled read word on `rdata`.

The serial link runs in SPI mode 0. SCLK idles low, the peripheral samples on the rising edge and the master changes MOSI on the falling edge. The SCLK half-period is a parameter counted in system clocks. `busy` covers the whole access and the enforced chip-select idle time that follows it. A surrounding system can use it to hold off its interrupt servicing while the peripheral is selected.

Top module: `spi_regxfer_master`

## Requirements
- R1: After reset `spi_csn` is 1, `spi_sclk` is 0, `busy` and `done` are 0 and `rdata` is zero.
- R2: With a sub-address of zero the header is one byte: bit 7 is the write flag (1 = write), bit 6 is 0 and bits 5:0 are the register ID.
- R3: With a sub-address of 1 to 127 the first header byte has bit 6 set, and a second byte follows with bit 7 clear and the sub-address in bits 6:0.
- R4: With a sub-address above 127 the second header byte has bit 7 set and holds sub-address bits 6:0, and a third byte holds sub-address bits 14:7.
- R5: In a write, data byte k is `req_wdata[8k+7:8k]`, sent in increasing k after the header. Every byte goes out most significant bit first.
- R6: In a read, MOSI carries 0x00 in every data byte. The k-th byte received after the header lands in `rdata[8k+7:8k]`, and all bits above the last received byte read zero, so a 5-byte read leaves bits 63:40 at zero.
- R7: SCLK is low whenever chip-select is high, and MOSI does not change while SCLK is high. One access produces exactly 8 × (header bytes + data bytes) rising SCLK edges.
- R8: Chip-select falls at least one SCLK half-period before the first rising edge. It rises at least one half-period after the last falling edge, with SCLK low at both transitions.
- R9: `done` is a one-cycle pulse in the same cycle that chip-select returns high. `rdata` is valid then and stays unchanged until the next accepted request; after a write it reads zero.
- R10: `busy` is high from the cycle after acceptance through exactly 2 × SCLK_HALF cycles counted from the `done` cycle. Chip-select therefore stays high for at least one full SCLK period between accesses.
- R11: A request presented while `busy` is high is ignored. It causes no extra chip-select cycle and does not alter the access in progress.
- R12: A byte count above MAX_BYTES is treated as MAX_BYTES. A byte count of zero gives a header-only access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_reg | input | 6 | Register ID |
| req_sub | input | 15 | Sub-address within the register |
| req_len | input | 4 | Data byte count (0 to MAX_BYTES) |
| req_wdata | input | 64 | Write data, byte 0 in bits 7:0 |
| busy | output | 1 | Access in progress or chip-select idle time running |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 64 | Read data, little-endian |
| spi_csn | output | 1 | Chip-select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the peripheral |
| spi_miso | input | 1 | Serial data from the peripheral |

## Verification
The header boundaries are the main target. The bench uses sub-addresses 0, 127, 128 and the all-ones value. A design with an off-by-one in the length choice would send the wrong number of header bytes, which misaligns every data byte and changes the SCLK edge count. Reads use a peripheral model whose bytes differ at every position. A byte-order or header-offset slip would therefore show up as wrong `rdata`, and a 5-byte read exposes stale upper bits. Further tests cover requests pulsed during a busy access, byte counts of 0 and 12, and back-to-back accesses. A design lacking the idle gap, clamping or request blocking would show a short chip-select high time, extra edges or a second select cycle.

// File: rtl/spi_regxfer_pkg.sv
package spi_regxfer_pkg;

    localparam int REG_ID_W  = 6;
    localparam int SUB_W     = 15;
    localparam int HDR_MAX   = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_HOLD,
        ST_GAP
    } xfer_state_e;

    typedef struct packed {
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] b2;
        logic [1:0] len;
    } hdr_t;

    // Header: byte0 = {write, sub_present, reg_id}; long sub-addresses set
    // bit 7 of byte1 and carry the upper bits in byte2.
    function automatic hdr_t make_header(input logic wr,
                                         input logic [REG_ID_W-1:0] rid,
                                         input logic [SUB_W-1:0] sub);
        hdr_t h;
        h.b0 = {wr, (sub != '0), rid};
        h.b1 = 8'h00;
        h.b2 = 8'h00;
        if (sub == '0) begin
            h.len = 2'd1;
        end else if (sub[SUB_W-1:7] == '0) begin
            h.len = 2'd2;
            h.b1  = {1'b0, sub[6:0]};
        end else begin
            h.len = 2'd3;
            h.b1  = {1'b1, sub[6:0]};
            h.b2  = sub[SUB_W-1:7];
        end
        return h;
    endfunction

endpackage

// File: rtl/spi_regxfer_tick.sv
module spi_regxfer_tick #(
    parameter int SCLK_HALF = 2,
    localparam int CW = $clog2(SCLK_HALF + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == CW'(SCLK_HALF - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign tick = run && (cnt == CW'(SCLK_HALF - 1));
endmodule

// File: rtl/spi_regxfer_frame.sv
module spi_regxfer_frame
    import spi_regxfer_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    localparam int LEN_W       = $clog2(MAX_BYTES + 1),
    localparam int FRAME_BYTES = HDR_MAX + MAX_BYTES,
    localparam int FRAME_BITS  = 8 * FRAME_BYTES,
    localparam int BIT_W       = $clog2(FRAME_BITS + 1)
) (
    input  logic                   wr,
    input  logic [REG_ID_W-1:0]    rid,
    input  logic [SUB_W-1:0]       sub,
    input  logic [LEN_W-1:0]       len,
    input  logic [8*MAX_BYTES-1:0] wdata,
    output logic [FRAME_BITS-1:0]  frame,
    output logic [BIT_W-1:0]       nbits,
    output logic [BIT_W-1:0]       hdr_bits
);
    hdr_t             hdr;
    logic [LEN_W-1:0] n_data;
    logic [7:0]       byte_v;

    always_comb begin
        hdr    = make_header(wr, rid, sub);
        n_data = (len > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : len;
        frame  = '0;
        byte_v = 8'h00;
        // Frame is MSB-first: byte 0 occupies the top eight bits.
        for (int i = 0; i < FRAME_BYTES; i++) begin
            byte_v = 8'h00;
            if (i < int'(hdr.len)) begin
                byte_v = (i == 0) ? hdr.b0 : (i == 1) ? hdr.b1 : hdr.b2;
            end else if (wr && ((i - int'(hdr.len)) < int'(n_data))) begin
                byte_v = 8'(wdata >> (8 * (i - int'(hdr.len))));
            end
            frame[FRAME_BITS-1-8*i -: 8] = byte_v;
        end
        nbits    = BIT_W'(8 * (int'(hdr.len) + int'(n_data)));
        hdr_bits = BIT_W'(8 * int'(hdr.len));
    end
endmodule

// File: rtl/spi_regxfer_shifter.sv
module spi_regxfer_shifter #(
    parameter int FRAME_BITS = 88,
    localparam int BIT_W = $clog2(FRAME_BITS + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  tick,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic [BIT_W-1:0]      nbits,
    output logic                  sclk,
    output logic                  mosi,
    output logic                  samp,
    output logic [BIT_W-1:0]      samp_idx,
    output logic                  last_fall
);
    logic             active;
    logic             sclk_q;
    logic [BIT_W-1:0] idx;
    logic             at_last;

    assign at_last = (idx == nbits - BIT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sclk_q <= 1'b0;
            idx    <= '0;
        end else if (start && !active) begin
            active <= 1'b1;
            sclk_q <= 1'b0;
            idx    <= '0;
        end else if (active && tick) begin
            if (!sclk_q) begin
                sclk_q <= 1'b1;
            end else begin
                sclk_q <= 1'b0;
                if (at_last) begin
                    active <= 1'b0;
                end else begin
                    idx <= idx + BIT_W'(1);
                end
            end
        end
    end

    assign sclk      = sclk_q;
    assign mosi      = active && frame[BIT_W'(FRAME_BITS - 1) - idx];
    assign samp      = active && tick && !sclk_q;
    assign samp_idx  = idx;
    assign last_fall = active && tick && sclk_q && at_last;
endmodule

// File: rtl/spi_regxfer_master.sv
module spi_regxfer_master
    import spi_regxfer_pkg::*;
#(
    parameter int SCLK_HALF = 2,
    parameter int MAX_BYTES = 8,
    localparam int LEN_W      = $clog2(MAX_BYTES + 1),
    localparam int DATA_W     = 8 * MAX_BYTES,
    localparam int DIDX_W     = $clog2(DATA_W),
    localparam int FRAME_BITS = 8 * (HDR_MAX + MAX_BYTES),
    localparam int BIT_W      = $clog2(FRAME_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [REG_ID_W-1:0] req_reg,
    input  logic [SUB_W-1:0]    req_sub,
    input  logic [LEN_W-1:0]    req_len,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                busy,
    output logic                done,
    output logic [DATA_W-1:0]   rdata,
    output logic                spi_csn,
    output logic                spi_sclk,
    output logic                spi_mosi,
    input  logic                spi_miso
);
    xfer_state_e           state;
    logic [FRAME_BITS-1:0] frame_d, frame_q;
    logic [BIT_W-1:0]      nbits_d, nbits_q;
    logic [BIT_W-1:0]      hbits_d, hbits_q;
    logic                  is_read_q;
    logic [DATA_W-1:0]     rdata_q;
    logic                  done_q, csn_q, gap_half;
    logic                  accept, tick;
    logic                  samp, last_fall;
    logic [BIT_W-1:0]      samp_idx, d_off;
    logic [DIDX_W-1:0]     rd_pos;

    assign accept = req_valid && (state == ST_IDLE);

    spi_regxfer_frame #(.MAX_BYTES(MAX_BYTES)) frame_i (
        .wr(req_write), .rid(req_reg), .sub(req_sub), .len(req_len),
        .wdata(req_wdata), .frame(frame_d), .nbits(nbits_d), .hdr_bits(hbits_d)
    );

    spi_regxfer_tick #(.SCLK_HALF(SCLK_HALF)) tick_i (
        .clk(clk), .rst(rst), .run(state != ST_IDLE), .tick(tick)
    );

    spi_regxfer_shifter #(.FRAME_BITS(FRAME_BITS)) shift_i (
        .clk(clk), .rst(rst), .start(accept), .tick(tick),
        .frame(frame_q), .nbits(nbits_q), .sclk(spi_sclk), .mosi(spi_mosi),
        .samp(samp), .samp_idx(samp_idx), .last_fall(last_fall)
    );

    // Data bit d lands at byte d/8, bit 7-(d%8): flipping the low 3 bits.
    assign d_off  = samp_idx - hbits_q;
    assign rd_pos = DIDX_W'(d_off ^ BIT_W'(7));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            frame_q   <= '0;
            nbits_q   <= '0;
            hbits_q   <= '0;
            is_read_q <= 1'b0;
            rdata_q   <= '0;
            done_q    <= 1'b0;
            csn_q     <= 1'b1;
            gap_half  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: if (accept) begin
                    frame_q   <= frame_d;
                    nbits_q   <= nbits_d;
                    hbits_q   <= hbits_d;
                    is_read_q <= !req_write;
                    rdata_q   <= '0;
                    csn_q     <= 1'b0;
                    state     <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (samp && is_read_q && (samp_idx >= hbits_q)) begin
                        rdata_q[rd_pos] <= spi_miso;
                    end
                    if (last_fall) state <= ST_HOLD;
                end
                ST_HOLD: if (tick) begin
                    csn_q    <= 1'b1;
                    done_q   <= 1'b1;
                    gap_half <= 1'b0;
                    state    <= ST_GAP;
                end
                ST_GAP: if (tick) begin
                    if (gap_half) state <= ST_IDLE;
                    else          gap_half <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state != ST_IDLE);
    assign done    = done_q;
    assign rdata   = rdata_q;
    assign spi_csn = csn_q;
endmodule

// File: rtl/spi_regxfer_master_chk.sv
module spi_regxfer_master_chk #(
    parameter int SCLK_HALF = 2,
    localparam int GAP  = 2 * SCLK_HALF,
    localparam int GW   = $clog2(GAP + 1)
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic spi_csn,
    input logic spi_sclk,
    input logic spi_mosi
);
    logic [GW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)                          hi_cnt <= GW'(GAP);
        else if (!spi_csn)                hi_cnt <= '0;
        else if (hi_cnt != GW'(GAP))      hi_cnt <= hi_cnt + GW'(1);
    end

    assert_sclk_idle_low_R7: assert property (@(posedge clk) disable iff (rst)
        spi_csn |-> !spi_sclk);

    assert_mosi_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    assert_first_edge_selected_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_sclk) |-> !$past(spi_csn));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_at_release_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_csn) |-> done);

    assert_selected_busy_R10: assert property (@(posedge clk) disable iff (rst)
        !spi_csn |-> busy);

    assert_cs_gap_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_csn) |-> (hi_cnt >= GW'(GAP)));

    assert_start_from_idle_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_csn) |-> !$past(busy));
endmodule

bind spi_regxfer_master spi_regxfer_master_chk #(.SCLK_HALF(SCLK_HALF)) chk_i (
    .clk(clk), .rst(rst), .busy(busy), .done(done),
    .spi_csn(spi_csn), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi)
);

// File: tb/spi_regxfer_master_tb_top.sv
module spi_regxfer_master_tb_top;
    localparam int HALF   = 2;
    localparam int MAXB   = 8;
    localparam int CLK_NS = 8;

    typedef struct packed {
        logic        wr;
        logic [5:0]  rid;
        logic [14:0] sub;
        logic [3:0]  len;
        logic [63:0] wd;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 6'h0D, 15'h0000, 4'd4, 64'h0000_0000_A1B2_C3D4},
        '{1'b0, 6'h00, 15'h0000, 4'd4, 64'h0},
        '{1'b1, 6'h23, 15'h0004, 4'd2, 64'h0000_0000_0000_8870},
        '{1'b0, 6'h12, 15'h007F, 4'd1, 64'h0},
        '{1'b1, 6'h2E, 15'h0806, 4'd1, 64'h0000_0000_0000_000D},
        '{1'b0, 6'h2E, 15'h1804, 4'd2, 64'h0},
        '{1'b0, 6'h3F, 15'h7FFF, 4'd8, 64'h0},
        '{1'b0, 6'h19, 15'h0000, 4'd5, 64'h0},
        '{1'b1, 6'h01, 15'h0080, 4'd8, 64'h0123_4567_89AB_CDEF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [5:0]  req_reg = '0;
    logic [14:0] req_sub = '0;
    logic [3:0]  req_len = '0;
    logic [63:0] req_wdata = '0;
    logic        busy, done, spi_csn, spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;
    logic [63:0] rdata;

    always #(CLK_NS/2) clk = ~clk;

    spi_regxfer_master #(.SCLK_HALF(HALF), .MAX_BYTES(MAXB)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_reg(req_reg), .req_sub(req_sub), .req_len(req_len),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
        .spi_csn(spi_csn), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    int n_checks = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- peripheral model ----------------
    logic [127:0] cap_bits = '0;
    int  sbit = 0, n_cs_fall = 0, mon_err = 0, gap_err = 0;
    time t_cs_fall = 0, t_cs_rise = 0, t_last_fall = 0;
    bit  seen_fall = 0, seen_rise = 0, pend_first = 0;

    function automatic logic [7:0] resp_byte(input int k);
        return 8'hC3 ^ 8'(k * 37);
    endfunction

    function automatic logic resp_bit(input int s);
        logic [7:0] b;
        b = resp_byte(s / 8);
        return b[7 - (s % 8)];
    endfunction

    function automatic logic [7:0] cap_byte(input int k);
        logic [7:0] r;
        for (int j = 0; j < 8; j++) r[7-j] = cap_bits[8*k+j];
        return r;
    endfunction

    initial forever begin
        @(negedge spi_csn);
        n_cs_fall++;
        if (spi_sclk) mon_err++;
        if (seen_rise && ($time - t_cs_rise < 2*HALF*CLK_NS)) gap_err++;
        t_cs_fall  = $time;
        seen_fall  = 1;
        pend_first = 1;
        sbit       = 0;
        cap_bits   = '0;
        spi_miso   = resp_bit(0);
    end

    initial forever begin
        @(posedge spi_sclk);
        if (spi_csn) mon_err++;
        if (pend_first && ($time - t_cs_fall < HALF*CLK_NS)) mon_err++;
        pend_first = 0;
        if (sbit < 128) cap_bits[sbit] = spi_mosi;
        sbit++;
    end

    initial forever begin
        @(negedge spi_sclk);
        spi_miso    = resp_bit(sbit);
        t_last_fall = $time;
    end

    initial forever begin
        @(posedge spi_csn);
        if (seen_fall) begin
            if (spi_sclk) mon_err++;
            if ($time - t_last_fall < HALF*CLK_NS) mon_err++;
            t_cs_rise = $time;
            seen_rise = 1;
        end
    end

    // ---------------- expected values from the requirements ----------------
    function automatic int exp_hlen(input logic [14:0] sub);
        return (sub == 0) ? 1 : (sub < 128) ? 2 : 3;
    endfunction

    function automatic logic [7:0] exp_hbyte(input logic wr, input logic [5:0] rid,
                                             input logic [14:0] sub, input int k);
        if (k == 0) return {wr, (sub != 0), rid};
        if (k == 1) return {(sub > 127), sub[6:0]};
        return sub[14:7];
    endfunction

    logic [63:0] got_rdata;
    bit          busy_at_start, done_csn;
    int          busy_cnt, extra_done;

    task automatic do_xfer(input logic wr, input logic [5:0] rid, input logic [14:0] sub,
                           input logic [3:0] len, input logic [63:0] wd);
        @(negedge clk);
        req_write = wr; req_reg = rid; req_sub = sub; req_len = len; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid     = 1'b0;
        busy_at_start = busy;
        while (!done) @(negedge clk);
        done_csn   = spi_csn;
        got_rdata  = rdata;
        busy_cnt   = 0;
        extra_done = 0;
        while (busy) begin
            busy_cnt++;
            @(negedge clk);
            if (done) extra_done++;
        end
    endtask

    task automatic run_vec(input vec_t v);
        int h, n;
        logic [63:0] exp_d, got_d, exp_r;
        string htag;
        do_xfer(v.wr, v.rid, v.sub, v.len, v.wd);
        h = exp_hlen(v.sub);
        n = (v.len > MAXB) ? MAXB : int'(v.len);
        htag = (h == 1) ? "R2" : (h == 2) ? "R3" : "R4";
        chk(sbit == 8*(h+n), "R7 edge count", 64'(sbit), 64'(8*(h+n)));
        for (int k = 0; k < h; k++)
            chk(cap_byte(k) == exp_hbyte(v.wr, v.rid, v.sub, k), htag,
                64'(cap_byte(k)), 64'(exp_hbyte(v.wr, v.rid, v.sub, k)));
        exp_d = '0; got_d = '0; exp_r = '0;
        for (int i = 0; i < n; i++) begin
            got_d[8*i +: 8] = cap_byte(h + i);
            if (v.wr) exp_d[8*i +: 8] = v.wd[8*i +: 8];
            else      exp_r[8*i +: 8] = resp_byte(h + i);
        end
        if (v.wr) begin
            chk(got_d == exp_d, "R5 write bytes", got_d, exp_d);
            chk(got_rdata == 64'h0, "R9 rdata after write", got_rdata, 64'h0);
        end else begin
            chk(got_d == 64'h0, "R6 read MOSI zero", got_d, 64'h0);
            chk(got_rdata == exp_r, "R6 read data", got_rdata, exp_r);
        end
        chk(busy_at_start, "R10 busy after accept", 64'(busy_at_start), 64'd1);
        chk(done_csn, "R9 done with cs release", 64'(done_csn), 64'd1);
        chk(extra_done == 0, "R9 done single pulse", 64'(extra_done), 64'd0);
        chk(busy_cnt == 2*HALF, "R10 busy tail", 64'(busy_cnt), 64'(2*HALF));
    endtask

    task automatic run_all();
        logic [63:0] held, exp_r;
        int falls0;
        // R1 reset state
        repeat (5) @(negedge clk);
        chk(spi_csn === 1'b1 && spi_sclk === 1'b0, "R1 pins in reset",
            {62'd0, spi_csn, spi_sclk}, 64'h2);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0, "R1 busy", 64'(busy), 64'd0);
        chk(done === 1'b0, "R1 done", 64'(done), 64'd0);
        chk(rdata === 64'h0, "R1 rdata", rdata, 64'h0);
        chk(spi_csn === 1'b1 && spi_sclk === 1'b0, "R1 pins after reset",
            {62'd0, spi_csn, spi_sclk}, 64'h2);

        // vector table, issued back to back
        for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

        // R6: 5-byte read keeps bits 63:40 clear
        do_xfer(1'b0, 6'h19, 15'h0000, 4'd5, 64'h0);
        chk(got_rdata[63:40] == 24'h0, "R6 upper bits zero", {40'd0, got_rdata[63:40]}, 64'h0);

        // R9: read data held after done
        held = got_rdata;
        repeat (12) @(negedge clk);
        chk(rdata == held, "R9 rdata held", rdata, held);

        // R11: requests during a busy access are ignored
        falls0 = n_cs_fall;
        @(negedge clk);
        req_write = 1'b0; req_reg = 6'h05; req_sub = 15'h0; req_len = 4'd2;
        req_valid = 1'b1;
        @(negedge clk);
        req_write = 1'b1; req_reg = 6'h3A; req_sub = 15'd300; req_len = 4'd8;
        req_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
        repeat (10) @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        got_rdata = rdata;
        while (busy) @(negedge clk);
        chk(n_cs_fall - falls0 == 1, "R11 single select", 64'(n_cs_fall - falls0), 64'd1);
        chk(cap_byte(0) == 8'h05, "R11 header kept", 64'(cap_byte(0)), 64'h05);
        chk(sbit == 24, "R11 length kept", 64'(sbit), 64'd24);
        exp_r = {48'd0, resp_byte(2), resp_byte(1)};
        chk(got_rdata == exp_r, "R11 read data kept", got_rdata, exp_r);

        // R12: count above MAX_BYTES is clamped
        do_xfer(1'b1, 6'h07, 15'h0, 4'd12, 64'h1122_3344_5566_7788);
        chk(sbit == 8*(1+MAXB), "R12 clamp edges", 64'(sbit), 64'(8*(1+MAXB)));
        begin
            logic [63:0] g;
            for (int i = 0; i < 8; i++) g[8*i +: 8] = cap_byte(1 + i);
            chk(g == 64'h1122_3344_5566_7788, "R12 clamp data", g, 64'h1122_3344_5566_7788);
        end
        // R12: zero count is header only
        do_xfer(1'b0, 6'h2A, 15'd5, 4'd0, 64'h0);
        chk(sbit == 16, "R12 header only", 64'(sbit), 64'd16);
        chk(got_rdata == 64'h0, "R12 header only rdata", got_rdata, 64'h0);

        // R8 / R10 monitor results over the whole run
        chk(mon_err == 0, "R8 select timing", 64'(mon_err), 64'd0);
        chk(gap_err == 0, "R10 select gap", 64'(gap_err), 64'd0);
    endtask

    initial begin
        bit timed_out;
        timed_out = 0;
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule